// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This peripheral holds several independent 32-bit down-counters that share one register bus, one input prescaler and one byte-wide run register. Each channel has its own reload value, live count and 16-bit control word. A channel that is running decrements by one on every prescaler pulse. When the prescaler pulse finds its count at zero, the channel loads the reload value, sets a sticky underflow flag, and raises its interrupt line if the interrupt is enabled.

Software chooses the kind of event by what it writes into the reload value. A reload equal to the wanted period gives periodic events. A reload of all ones gives the longest possible gap, which serves as a one-shot. Elapsed time is the bitwise complement of the live count. To reprogram a channel, software clears its run bit, services the control word, writes the reload value and then the count, and finally sets the run bit again.

The bus is a simple single-cycle slave. Writes are byte, halfword or word wide and use byte lanes: byte k of a word sits in write-data bits 8k+7..8k. Read data is always the whole addressed word and is valid in the same cycle as the address.

Top module: `reload_timer`

## Requirements
- R1: After reset, the run register reads 0, every reload value and every count reads 0xFFFFFFFF, every control word reads 0, and all interrupt lines are low.
- R2: The run register is byte lane 0 of the word at 0x00, with bit n for channel n. Channel n's window starts at 0x10*(n+1). In that window the reload value is at +0x0, the count at +0x4 and the control word at +0x8 (lanes 0–1). Any other address reads 0.
- R3: The size code is 0 for a byte, 1 for a halfword and 2 or 3 for a word. A write changes only the byte lanes it selects: a byte write selects lane addr[1:0], and a halfword write selects lanes starting at {addr[1],0}.
- R4: The prescaler pulses once every 4 clocks. The first pulse comes in the 4th cycle after reset is released. A running channel decrements once per pulse.
- R5: While a channel's run bit is clear, its count holds its value.
- R6: A pulse that finds a running count at zero loads the reload value into the count and sets control bit 8, the underflow flag.
- R7: Control bit 5 enables the interrupt. Each channel's interrupt line is the level AND of its flag and its enable.
- R8: Writing lane 1 of the control word with bit 8 at 0 clears the flag. Writing it with bit 8 at 1 leaves the flag unchanged, so a write never sets it. If an underflow happens in the same cycle as a clearing write, the flag stays set.
- R9: A write to the count or the reload value takes effect in the next cycle, whether or not the channel is running. A count write overrides a prescaler pulse in the same cycle, and no underflow occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data on byte lanes |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq | output | NCH | Level interrupt for each channel |

## Verification
Read data is combinational from the address, so each read is checked in the same cycle, a quarter period after the address is driven. A register write is sampled at a rising edge and shows up in reads from the next cycle on. A count changes in the cycle after a prescaler-phase-3 cycle, and an interrupt line follows its flag or enable one edge after the event. The bench drives inputs on falling edges and advances its behavioural model on rising edges. It compares every interrupt line in every cycle and each read word at the same mid-low point, so each result is checked in exactly the cycle it is due.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int DW         = 32;
  localparam int CTL_W      = 16;
  localparam int CTL_IE_BIT = 5;
  localparam int CTL_UF_BIT = 8;

  // byte lanes touched by an access of the given size at the given low address bits
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] lo);
    logic [3:0] m;
    case (size)
      2'd0:    m = 4'b0001 << lo;
      2'd1:    m = lo[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] old_v,
                                                input logic [DW-1:0] new_v,
                                                input logic [3:0]    m);
    logic [DW-1:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = m[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] count_step(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] reload);
    return (cur == '0) ? reload : cur - 1'b1;
  endfunction
endpackage

// File: rtl/rtmr_prescale.sv
module rtmr_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] phase_q;

  assign tick_o = (phase_q == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (tick_o) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel
  import rtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [3:0]       be_i,
  input  logic             rl_we_i,
  input  logic             cnt_we_i,
  input  logic             ctl_we_i,
  output logic [DW-1:0]    rl_o,
  output logic [DW-1:0]    cnt_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             flag_o,
  output logic             ie_o,
  output logic             uf_o,
  output logic             irq_o
);
  logic [DW-1:0] rl_q, cnt_q;
  logic          ie_q, flag_q;
  logic          step_w;

  assign step_w = run_i && tick_i && !cnt_we_i;
  assign uf_o   = step_w && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_q  <= '1;
      cnt_q <= '1;
    end else begin
      if (rl_we_i)       rl_q  <= merge_lanes(rl_q, wdata_i, be_i);
      if (cnt_we_i)      cnt_q <= merge_lanes(cnt_q, wdata_i, be_i);
      else if (step_w)   cnt_q <= count_step(cnt_q, rl_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_we_i && be_i[0]) ie_q <= wdata_i[CTL_IE_BIT];
      if (uf_o)                flag_q <= 1'b1;
      else if (ctl_we_i && be_i[1] && !wdata_i[CTL_UF_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_o             = '0;
    ctl_o[CTL_IE_BIT] = ie_q;
    ctl_o[CTL_UF_BIT] = flag_q;
  end

  assign rl_o   = rl_q;
  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign irq_o  = flag_q && ie_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtmr_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int PRE_DIV = 4,
  parameter int AW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int WIN_W = AW - 4;

  logic [WIN_W-1:0]           win_w;
  logic [1:0]                 reg_w;
  logic [3:0]                 be_w;
  logic                       tick_w;
  logic [NCH-1:0]             run_q;
  logic [NCH-1:0]             uf_w, flag_w, ie_w;
  logic [NCH-1:0]             rl_we_w, cnt_we_w, ctl_we_w;
  logic [NCH-1:0][DW-1:0]     rl_all, cnt_all;
  logic [NCH-1:0][CTL_W-1:0]  ctl_all;

  assign win_w = bus_addr[AW-1:4];
  assign reg_w = bus_addr[3:2];
  assign be_w  = lane_mask(bus_size, bus_addr[1:0]);

  rtmr_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (bus_we && win_w == '0 && reg_w == 2'd0 && be_w[0])
      run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit_w;
    assign hit_w       = bus_we && (win_w == WIN_W'(c + 1));
    assign rl_we_w[c]  = hit_w && reg_w == 2'd0;
    assign cnt_we_w[c] = hit_w && reg_w == 2'd1;
    assign ctl_we_w[c] = hit_w && reg_w == 2'd2;

    rtmr_channel u_ch (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .run_i(run_q[c]),
      .wdata_i(bus_wdata), .be_i(be_w),
      .rl_we_i(rl_we_w[c]), .cnt_we_i(cnt_we_w[c]), .ctl_we_i(ctl_we_w[c]),
      .rl_o(rl_all[c]), .cnt_o(cnt_all[c]), .ctl_o(ctl_all[c]),
      .flag_o(flag_w[c]), .ie_o(ie_w[c]), .uf_o(uf_w[c]), .irq_o(irq[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (win_w == '0 && reg_w == 2'd0) bus_rdata[NCH-1:0] = run_q;
    for (int c = 0; c < NCH; c++) begin
      if (win_w == WIN_W'(c + 1)) begin
        case (reg_w)
          2'd0:    bus_rdata = rl_all[c];
          2'd1:    bus_rdata = cnt_all[c];
          2'd2:    bus_rdata = {{(DW-CTL_W){1'b0}}, ctl_all[c]};
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtmr_chk.sv
module rtmr_chk #(
  parameter int NCH = 3,
  parameter int DIV = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0]         uf,
  input logic [NCH-1:0]         flag,
  input logic [NCH-1:0]         ie,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0]         cnt_we,
  input logic [NCH-1:0]         ctl_we,
  input logic [NCH-1:0][31:0]   cnt_all,
  input logic [NCH-1:0][31:0]   rl_all
);
  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  // R4
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap_q == 16'(DIV - 1));

  for (genvar c = 0; c < NCH; c++) begin : g_a
    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[c] && !cnt_we[c]) |=> $stable(cnt_all[c]));
    // R6
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf[c] |=> cnt_all[c] == $past(rl_all[c]));
    // R6
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf[c] |=> flag[c]);
    // R8
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[c]) |-> $past(uf[c]));
    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf[c] && ie[c] && !ctl_we[c]) |=> irq[c]);
  end
endmodule

bind reload_timer rtmr_chk #(.NCH(NCH), .DIV(PRE_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .run(run_q), .uf(uf_w),
  .flag(flag_w), .ie(ie_w), .irq(irq), .cnt_we(cnt_we_w), .ctl_we(ctl_we_w),
  .cnt_all(cnt_all), .rl_all(rl_all)
);

// File: tb/sim_reload_timer.sv
module sim_reload_timer;
  localparam int NCH = 3;
  localparam int DIV = 4;
  localparam int AW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_we = 1'b0;
  logic [1:0]      bus_size = 2'd2;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  reload_timer #(.NCH(NCH), .PRE_DIV(DIV), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_rl  [NCH];
  logic [31:0] m_cnt [NCH];
  bit          m_ie  [NCH];
  bit          m_flag[NCH];
  bit [7:0]    m_run;
  int          m_phase;

  function automatic bit [3:0] mdl_lanes(input int size, input int lo);
    int nb, first;
    bit [3:0] m;
    nb    = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    first = (size == 0) ? lo : (size == 1) ? (lo & 2) : 0;
    m = '0;
    for (int i = first; i < first + nb; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] mdl_read(input int a);
    int ch, off;
    ch  = a / 16;
    off = (a % 16) / 4;
    if (ch == 0) return (off == 0) ? {24'h0, m_run} : 32'h0;
    if (ch > NCH) return 32'h0;
    case (off)
      0: return m_rl[ch-1];
      1: return m_cnt[ch-1];
      2: return (32'(m_flag[ch-1]) << 8) | (32'(m_ie[ch-1]) << 5);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_rl[c] = '1; m_cnt[c] = '1; m_ie[c] = 0; m_flag[c] = 0;
      end
      m_run = '0; m_phase = 0;
    end else begin
      bit tk, uf;
      bit [3:0] ln;
      bit [7:0] run_old;
      int a, ch, off;
      tk = (m_phase == DIV - 1);
      m_phase = (m_phase + 1) % DIV;
      a   = int'(bus_addr);
      ch  = a / 16 - 1;
      off = (a % 16) / 4;
      ln  = mdl_lanes(int'(bus_size), a % 4);
      run_old = m_run;
      for (int c = 0; c < NCH; c++) begin
        bit wr_here;
        wr_here = bus_we && ch == c;
        uf = 0;
        if (wr_here && off == 1) begin
          for (int b = 0; b < 4; b++) if (ln[b]) m_cnt[c][8*b +: 8] = bus_wdata[8*b +: 8];
        end else if (run_old[c] && tk) begin
          if (m_cnt[c] == 0) begin uf = 1; m_cnt[c] = m_rl[c]; end
          else m_cnt[c] = m_cnt[c] - 1;
        end
        if (wr_here && off == 0)
          for (int b = 0; b < 4; b++) if (ln[b]) m_rl[c][8*b +: 8] = bus_wdata[8*b +: 8];
        if (wr_here && off == 2) begin
          if (ln[0]) m_ie[c] = bus_wdata[5];
          if (ln[1] && !bus_wdata[8]) m_flag[c] = 0;
        end
        if (uf) m_flag[c] = 1;
      end
      if (bus_we && a / 4 == 0 && ln[0]) m_run = bus_wdata[7:0] & 8'((1 << NCH) - 1);
    end
  end

  // R7: interrupt lines compared every cycle
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      logic [NCH-1:0] exp_irq;
      for (int c = 0; c < NCH; c++) exp_irq[c] = m_flag[c] & m_ie[c];
      n_chk++;
      if (irq !== exp_irq) begin
        n_bad++;
        $display("FAIL R7 irq cycle %0d: got %b expected %b", cyc, irq, exp_irq);
      end
    end
  end

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_up();
    end
  end

  task automatic wr(input int a, input int size, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_size = 2'(size); bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = AW'(a);
    #5;
    e = mdl_read(a);
    n_chk++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s read 0x%0h: got %h expected %h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic rd_exp(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = AW'(a);
    #5;
    n_chk++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s read 0x%0h: got %h expected %h", tag, a, bus_rdata, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values, fixed expectations
    rd_exp(32'h00, 32'h0, "R1");
    for (int c = 0; c < NCH; c++) begin
      rd_exp(16*(c+1) + 0, 32'hFFFF_FFFF, "R1");
      rd_exp(16*(c+1) + 4, 32'hFFFF_FFFF, "R1");
      rd_exp(16*(c+1) + 8, 32'h0, "R1");
    end
    // R2 unmapped addresses
    rd_exp(32'hF0, 32'h0, "R2");
    rd_exp(32'h1C, 32'h0, "R2");
    rd_exp(32'h04, 32'h0, "R2");
    // R3 lane writes on channel 0 reload
    wr(32'h11, 0, 32'h0000_5500);
    rd_exp(32'h10, 32'hFFFF_55FF, "R3");
    wr(32'h12, 1, 32'h1234_0000);
    rd_exp(32'h10, 32'h1234_55FF, "R3");
    wr(32'h10, 2, 32'h0000_0005);
    rd_exp(32'h10, 32'h0000_0005, "R3");
    // channel 0 periodic with interrupt
    wr(32'h18, 1, 32'h0000_0020);
    wr(32'h14, 2, 32'h0000_0002);
    wr(32'h00, 0, 32'h0000_0001);
    for (int i = 0; i < 40; i++) rd(32'h14, "R4");
    rd(32'h18, "R6");
    // R8 clear then try to set by write
    wr(32'h18, 1, 32'h0000_0020);
    rd(32'h18, "R8");
    wr(32'h18, 1, 32'h0000_0120);
    rd(32'h18, "R8");
    for (int i = 0; i < 30; i++) rd(32'h18, "R8");
    // R5 halt channel 0, count must hold
    wr(32'h00, 0, 32'h0);
    for (int i = 0; i < 12; i++) rd(32'h14, "R5");
    // R9 halted writes land next cycle
    wr(32'h14, 2, 32'h0000_0003);
    rd(32'h14, "R9");
    // channel 1 without interrupt, channel 2 long gap
    wr(32'h20, 2, 32'h0000_0001);
    wr(32'h24, 2, 32'h0000_0000);
    wr(32'h00, 0, 32'h0000_0007);
    for (int i = 0; i < 60; i++) begin
      rd(32'h24, "R6");
      rd(32'h34, "R4");
    end
    rd(32'h28, "R7");
    // R9 write count while running, repeatedly at each phase
    for (int i = 0; i < 8; i++) begin
      wr(32'h34, 2, 32'h0000_0010 + 32'(i));
      rd(32'h34, "R9");
      rd(32'h30, "R9");
    end
    // reload change while running, then observe underflows
    wr(32'h30, 2, 32'h0000_0002);
    wr(32'h38, 1, 32'h0000_0020);
    for (int i = 0; i < 80; i++) begin
      rd(32'h34, "R6");
      rd(32'h38, "R8");
    end
    // R8 clear attempts repeated across prescaler phases (set-wins race)
    for (int i = 0; i < 16; i++) begin
      wr(32'h39, 0, 32'h0000_0000);
      rd(32'h38, "R8");
    end
    // R7 disable enable drops irq
    wr(32'h38, 0, 32'h0000_0000);
    rd(32'h38, "R7");
    rd(32'h00, "R2");
    finish_up();
  end
endmodule